// File: doc/BRIEF.md
# Comma-Based Word Aligner

This block recovers the symbol framing of a raw stream coming out of a deserializer. The deserializer hands over 20 bits per clock (two 10-bit symbols), but the position of the symbol boundary inside those bits is arbitrary. The block keeps the previous word next to the current one. In the combined bits it looks, at every one of the 20 possible starting positions, for the 7-bit prefix of a comma character in either running-disparity form.

The first comma found fixes the boundary. From then on, every output word is a 20-bit slice taken from that two-word history at the locked position, so each output word starts on a symbol boundary. A downstream 8b/10b decoder can then take the output as it is.

While locked, a comma at a different position is treated as noise unless the consumer raises `realign`. A comma at the locked position produces a one-cycle `comma_seen` strobe. Stalls on the input (valid low) freeze all state.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `byte_aligned`, `comma_seen`, `out_valid` and `out_data` after that edge, and the locked position returns to 0.
- R2: Bit 0 of each word is the earliest bit on the line. The search window W has 40 bits: W[j] is bit j of the previous accepted word for j < 20, and bit j-20 of the current `in_data` for j >= 20. One clock after a word is accepted, `out_valid` is 1 and `out_data[i]` = W[p+i], where p is the position in force for that word. Before the first accepted word, the previous word reads as zeros.
- R3: A comma starts at position k (0..19) when W[k..k+6], read in line order, is 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0.
- R4: While unaligned, an accepted word whose window holds a comma causes three things after that edge: the position is locked to that comma, `byte_aligned` goes high, and `comma_seen` is high for one cycle. The output word for that same input already uses the new position.
- R5: When a position is being taken and the window holds several commas, the lowest position wins.
- R6: While aligned and `realign` is low, a comma at any position other than the locked one changes nothing: the slicing position stays the same and `comma_seen` stays low.
- R7: While aligned, a comma at the locked position raises `comma_seen` for one cycle and leaves the position unchanged.
- R8: While aligned, an accepted word with `realign` high and a comma in its window moves the position to that comma and raises `comma_seen`. With `realign` high and no comma in the window, nothing changes.
- R9: A cycle with `in_valid` low changes no state, whatever `realign` and `in_data` are. After that edge `out_valid` and `comma_seen` are low, and `out_data` keeps its value.
- R10: Until the first comma, `byte_aligned` is low and the words pass at position 0, which means `out_data` equals the previous accepted word.
- R11: Once high, `byte_aligned` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 20 | Raw deserialized word, bit 0 earliest on the line |
| in_valid | input | 1 | `in_data` is a new word this cycle |
| realign | input | 1 | Allows a locked boundary to move to a newly found comma |
| out_data | output | 20 | Boundary-aligned word |
| out_valid | output | 1 | `out_data` was produced from a word accepted on the previous edge |
| byte_aligned | output | 1 | A boundary has been locked since reset |
| comma_seen | output | 1 | One-cycle strobe: a comma was accepted or confirmed |

## Verification
The assertions assume that `rst_n` is low for the first clock edges and that every input is driven to a known level away from the edge. The stimulus meets this by starting every stream with a two-cycle reset and by driving all inputs at the falling edge.

The bench builds each bit stream so that commas appear only where it places them. Filler bits never run longer than four equal bits, and the bit just before a comma is forced to the opposite of the comma's first bit. This way, the comma list the expected-value model works from is the complete set of matches the block can find. All 20 positions are swept for both comma forms, together with stalls, confirmations, ignored commas, realignment and competing commas.

// File: rtl/wa_pkg.sv
// Package: constants and decision type shared by the word aligner.
// Comma prefixes are stored with bit i equal to the i-th bit received on the line.
package wa_pkg;
    localparam int unsigned SYM_BITS    = 10;
    localparam int unsigned PREFIX_BITS = 7;

    // Line order 0,0,1,1,1,1,1 (positive disparity form of the comma).
    localparam logic [PREFIX_BITS-1:0] PREFIX_PLUS  = 7'b1111100;
    // Line order 1,1,0,0,0,0,0 (negative disparity form).
    localparam logic [PREFIX_BITS-1:0] PREFIX_MINUS = 7'b0000011;

    // What the boundary control does with the current word.
    typedef enum logic [1:0] {
        DEC_NONE    = 2'd0,
        DEC_LOCK    = 2'd1,
        DEC_CONFIRM = 2'd2,
        DEC_IGNORE  = 2'd3
    } wa_decision_e;
endpackage

// File: rtl/wa_comma_scan.sv
// Module: wa_comma_scan
// Matches the comma prefix at every candidate start position of the window.
// Assumes: the window holds WORD_W+PRE_W-1 bits, with bit 0 earliest, so that
// position N_OFF-1 still has a full prefix available.
module wa_comma_scan #(
    parameter int unsigned WORD_W = 20,
    parameter int unsigned PRE_W  = 7,
    parameter logic [PRE_W-1:0] PAT_A = 7'b1111100,
    parameter logic [PRE_W-1:0] PAT_B = 7'b0000011
) (
    input  logic [WORD_W+PRE_W-2:0] scan_win,
    output logic [WORD_W-1:0]       hit
);
    // One comparator pair for each start position.
    for (genvar k = 0; k < WORD_W; k++) begin : g_pos
        logic [PRE_W-1:0] seg;
        assign seg    = scan_win[k +: PRE_W];
        assign hit[k] = (seg == PAT_A) || (seg == PAT_B);
    end
endmodule

// File: rtl/wa_boundary_ctl.sv
// Module: wa_boundary_ctl
// Holds the locked boundary position and the aligned flag, and decides per word
// whether a comma locks, confirms or is ignored.
// Assumes: hit is valid for the word on in_valid; positions outside 0..N_OFF-1
// never occur.
module wa_boundary_ctl
    import wa_pkg::*;
#(
    parameter int unsigned N_OFF = 20,
    parameter int unsigned OFF_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             realign,
    input  logic [N_OFF-1:0] hit,
    output logic [OFF_W-1:0] use_off,
    output logic [OFF_W-1:0] lock_off,
    output logic             locked,
    output logic             seen
);
    logic [OFF_W-1:0] first_hit;
    logic             any_hit;
    wa_decision_e     decision;

    // Lowest position holding a comma.
    always_comb begin
        first_hit = '0;
        for (int k = N_OFF - 1; k >= 0; k--) begin
            if (hit[k]) first_hit = OFF_W'(k);
        end
    end

    assign any_hit = |hit;

    // Classify the current word.
    always_comb begin
        decision = DEC_NONE;
        if (in_valid && any_hit) begin
            if (!locked || realign)  decision = DEC_LOCK;
            else if (hit[lock_off])  decision = DEC_CONFIRM;
            else                     decision = DEC_IGNORE;
        end
    end

    // Position used to slice this word: a new lock takes effect at once.
    assign use_off = (decision == DEC_LOCK) ? first_hit : lock_off;

    // Register the position, the lock flag and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_off <= '0;
            locked   <= 1'b0;
            seen     <= 1'b0;
        end else begin
            lock_off <= use_off;
            locked   <= locked || (decision == DEC_LOCK);
            seen     <= (decision == DEC_LOCK) || (decision == DEC_CONFIRM);
        end
    end
endmodule

// File: rtl/wa_word_slicer.sv
// Module: wa_word_slicer
// Keeps the previous accepted word, exposes the search window and registers the
// output slice at the selected position.
// Assumes: sel_off < WORD_W; SCAN_W <= 2*WORD_W-1.
module wa_word_slicer #(
    parameter int unsigned WORD_W = 20,
    parameter int unsigned OFF_W  = 5,
    parameter int unsigned SCAN_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [OFF_W-1:0]  sel_off,
    output logic [SCAN_W-1:0] scan_win,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid
);
    localparam int unsigned WIN_W = 2 * WORD_W - 1;

    logic [WORD_W-1:0] prev_q;
    logic [WIN_W-1:0]  win;
    logic [WORD_W-1:0] slice;

    // Window: previous word in the low bits, current word above it.
    assign win      = {in_data[WORD_W-2:0], prev_q};
    assign scan_win = win[SCAN_W-1:0];

    // Select the slice that starts at the chosen position.
    always_comb begin
        slice = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (sel_off == OFF_W'(k)) slice = win[k +: WORD_W];
        end
    end

    // Advance the history and the output only on accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prev_q   <= in_data;
                out_data <= slice;
            end
        end
    end
endmodule

// File: rtl/comma_word_aligner.sv
// Module: comma_word_aligner (top)
// Finds a comma in a raw deserialized stream at any bit position, locks the
// symbol boundary there and emits boundary-aligned words one clock later.
// Assumes: bit 0 of in_data is the earliest bit on the line; the width is a
// whole number of 10-bit symbols.
module comma_word_aligner #(
    parameter int unsigned SYM_W = wa_pkg::SYM_BITS,
    parameter int unsigned SYMS  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SYM_W*SYMS-1:0]   in_data,
    input  logic                    in_valid,
    input  logic                    realign,
    output logic [SYM_W*SYMS-1:0]   out_data,
    output logic                    out_valid,
    output logic                    byte_aligned,
    output logic                    comma_seen
);
    localparam int unsigned WORD_W = SYM_W * SYMS;
    localparam int unsigned OFF_W  = $clog2(WORD_W);
    localparam int unsigned SCAN_W = WORD_W + wa_pkg::PREFIX_BITS - 1;

    logic [SCAN_W-1:0] scan_win;
    logic [WORD_W-1:0] hit;
    logic [OFF_W-1:0]  use_off;
    logic [OFF_W-1:0]  lock_off;

    // History and output slicing.
    wa_word_slicer #(
        .WORD_W (WORD_W),
        .OFF_W  (OFF_W),
        .SCAN_W (SCAN_W)
    ) u_slicer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .sel_off   (use_off),
        .scan_win  (scan_win),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Comma search at every position.
    wa_comma_scan #(
        .WORD_W (WORD_W),
        .PRE_W  (wa_pkg::PREFIX_BITS),
        .PAT_A  (wa_pkg::PREFIX_PLUS),
        .PAT_B  (wa_pkg::PREFIX_MINUS)
    ) u_scan (
        .scan_win (scan_win),
        .hit      (hit)
    );

    // Lock decision and state.
    wa_boundary_ctl #(
        .N_OFF (WORD_W),
        .OFF_W (OFF_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .realign  (realign),
        .hit      (hit),
        .use_off  (use_off),
        .lock_off (lock_off),
        .locked   (byte_aligned),
        .seen     (comma_seen)
    );
endmodule

// File: rtl/wa_aligner_chk.sv
// Module: wa_aligner_chk
// Temporal checks on the aligner ports and the locked position, attached by bind.
// Assumes: rst_n is low at the first clock edges.
module wa_aligner_chk #(
    parameter int unsigned WORD_W = 20,
    parameter int unsigned OFF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              realign,
    input logic [WORD_W-1:0] out_data,
    input logic              out_valid,
    input logic              byte_aligned,
    input logic              comma_seen,
    input logic [OFF_W-1:0]  lock_off
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_FIRST_LOCK_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(byte_aligned) |-> comma_seen); // R4
    AST_LOCKED_POS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (byte_aligned && !realign) |=> $stable(lock_off)); // R6
    AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) comma_seen |-> (byte_aligned && out_valid)); // R7
    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && !comma_seen && $stable(out_data))); // R9
    AST_UNLOCKED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !byte_aligned |-> (lock_off == '0)); // R10
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) byte_aligned |=> byte_aligned); // R11
endmodule

bind comma_word_aligner wa_aligner_chk #(
    .WORD_W (WORD_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .realign      (realign),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .byte_aligned (byte_aligned),
    .comma_seen   (comma_seen),
    .lock_off     (lock_off)
);

// File: tb/tb_comma_word_aligner.sv
// Bench: builds bit streams with commas at chosen positions, feeds them word by
// word and compares every output against a model driven by the comma list.
module tb_comma_word_aligner;
    localparam int WW    = 20;
    localparam int NW    = 16;
    localparam int NBITS = NW * WW;
    localparam logic [0:9] CPLUS = 10'b0011111010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          realign = 1'b0;
    logic [WW-1:0] out_data;
    logic          out_valid;
    logic          byte_aligned;
    logic          comma_seen;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic       sb [0:NBITS-1];
    int         cm [0:NBITS-1];
    bit         rl_w [0:NW-1];
    bit         gap_w [0:NW-1];
    logic [15:0] lfsr = 16'hACE1;

    int            e_off;
    bit            e_al;
    logic [WW-1:0] e_out;

    always #4 clk = ~clk;

    comma_word_aligner dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .realign      (realign),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .byte_aligned (byte_aligned),
        .comma_seen   (comma_seen)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
            report();
        end
    end

    task automatic chk_bit(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_word(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s out_data: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic ebit(int j);
        return (j < 0) ? 1'b0 : sb[j];
    endfunction

    task automatic clear_plan();
        for (int p = 0; p < NBITS; p++) cm[p] = 0;
        for (int w = 0; w < NW; w++) begin
            rl_w[w] = 1'b0;
            gap_w[w] = 1'b0;
        end
    endtask

    // Filler runs stay short, the bit before a comma opposes its first bit.
    task automatic build();
        int p = 0;
        while (p < NBITS) begin
            if (cm[p] != 0) begin
                for (int i = 0; i < 10; i++) sb[p + i] = (cm[p] == 1) ? CPLUS[i] : ~CPLUS[i];
                p += 10;
            end else if (p + 1 < NBITS && cm[p + 1] != 0) begin
                sb[p] = (cm[p + 1] == 1) ? 1'b1 : 1'b0;
                p++;
            end else begin
                logic b;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                b = lfsr[0];
                if (p >= 3 && sb[p-1] == sb[p-2] && sb[p-2] == sb[p-3] && b == sb[p-1]) b = ~b;
                sb[p] = b;
                p++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        realign = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        chk_bit("R1", "byte_aligned", byte_aligned, 1'b0);
        chk_bit("R1", "comma_seen", comma_seen, 1'b0);
        chk_bit("R1", "out_valid", out_valid, 1'b0);
        chk_word("R1", out_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        e_off = 0;
        e_al = 1'b0;
        e_out = '0;
    endtask

    // Stall cycle with realign high: R9.
    task automatic idle_step();
        @(negedge clk);
        in_valid = 1'b0;
        realign = 1'b1;
        in_data = 20'hABCDE;
        @(posedge clk);
        #2;
        chk_bit("R9", "out_valid", out_valid, 1'b0);
        chk_bit("R9", "comma_seen", comma_seen, 1'b0);
        chk_bit("R9", "byte_aligned", byte_aligned, e_al);
        chk_word("R9", out_data, e_out);
    endtask

    task automatic word_step(int n);
        int    base = WW * (n - 1);
        int    cnt = 0;
        int    lo = -1;
        bit    cur = 1'b0;
        bit    seen;
        string tag;
        @(negedge clk);
        for (int i = 0; i < WW; i++) in_data[i] = sb[WW * n + i];
        in_valid = 1'b1;
        realign = rl_w[n];
        for (int k = 0; k < WW; k++) begin
            if (base + k >= 0 && cm[base + k] != 0) begin
                cnt++;
                if (lo < 0) lo = k;
                if (k == e_off) cur = 1'b1;
            end
        end
        if (lo >= 0 && (!e_al || rl_w[n])) begin
            seen = 1'b1;
            tag = (cnt > 1) ? "R5" : (e_al ? "R8" : "R3 R4");
            e_off = lo;
            e_al = 1'b1;
        end else if (e_al && cur) begin
            seen = 1'b1;
            tag = "R7";
        end else if (lo >= 0) begin
            seen = 1'b0;
            tag = "R6";
        end else begin
            seen = 1'b0;
            tag = (e_al && rl_w[n]) ? "R8" : (e_al ? "R2 R11" : "R10");
        end
        for (int i = 0; i < WW; i++) e_out[i] = ebit(base + e_off + i);
        @(posedge clk);
        #2;
        chk_bit(tag, "out_valid", out_valid, 1'b1);
        chk_word(tag, out_data, e_out);
        chk_bit(tag, "byte_aligned", byte_aligned, e_al);
        chk_bit(tag, "comma_seen", comma_seen, seen);
    endtask

    task automatic run_stream();
        do_reset();
        build();
        for (int n = 0; n < NW; n++) begin
            if (gap_w[n]) idle_step();
            word_step(n);
        end
    endtask

    initial begin
        // Sweep every position for both comma forms (R3, R4, R6, R7, R8, R9).
        for (int pol = 1; pol <= 2; pol++) begin
            for (int k = 0; k < WW; k++) begin
                clear_plan();
                cm[60 + k] = pol;
                cm[160 + k] = pol;
                cm[220 + (k + 7) % WW] = 3 - pol;
                cm[280 + (k + 3) % WW] = pol;
                rl_w[6] = 1'b1;
                rl_w[15] = 1'b1;
                gap_w[4] = 1'b1;
                gap_w[10] = 1'b1;
                run_stream();
            end
        end
        // Competing commas: lowest position wins (R5), on lock and on realign.
        clear_plan();
        cm[42] = 2;
        cm[53] = 1;
        cm[113] = 1;
        cm[205] = 1;
        cm[216] = 2;
        rl_w[11] = 1'b1;
        run_stream();
        // Reset out of the aligned state (R1).
        do_reset();
        report();
    end
endmodule